// File: doc/BRIEF.md
# Segmented physical address generator

This block turns a 16-bit segment base and a 16-bit offset into a 20-bit physical memory address. For each memory reference it also picks which of four segment registers (code, data, stack, extra) supplies the base. The choice depends on the kind of reference, and it may be redirected by a one-shot override. A one-byte prefix loads that override, and it covers only the instruction that follows the prefix.

The surrounding core presents the reference kind, the four segment register values and the already computed offset. It pulses a prefix strobe when an override prefix is consumed and an instruction-boundary strobe when an instruction ends. The address and the chosen segment are combinational from these inputs and the latched override state. Some reference kinds never accept an override. On those kinds a pending override is ignored.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr` equals (selected segment value × 16 + `offset`) modulo 2^20, so a carry out of bit 19 is discarded.
- R2: With `ref_kind` = 0 (instruction fetch) the code segment is used, and `seg_used` = 2'b01, whatever override is pending. Segment codes are 00 extra, 01 code, 10 stack, 11 data.
- R3: With `ref_kind` = 1 (stack operation) the stack segment is used (`seg_used` = 2'b10), and any pending override is ignored.
- R4: With `ref_kind` = 2 (general variable), or the spare codes 6 and 7, the data segment (11) is used unless an override is pending, in which case the override segment is used.
- R5: With `ref_kind` = 3 (string source) the data segment is used by default, and a pending override replaces it.
- R6: With `ref_kind` = 4 (string destination) the extra segment (00) is always used, and any pending override is ignored.
- R7: With `ref_kind` = 5 (base-pointer-relative) the stack segment (10) is used by default, and a pending override replaces it.
- R8: A clock edge with `pfx_valid` high latches `pfx_seg` as the pending override, which takes effect from the next cycle. An edge with `insn_end` high and `pfx_valid` low clears it. If both strobes are high on the same edge, the new prefix is kept.
- R9: Reset leaves no override pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_kind | input | 3 | Memory reference kind |
| seg_es | input | 16 | Extra segment register value |
| seg_cs | input | 16 | Code segment register value |
| seg_ss | input | 16 | Stack segment register value |
| seg_ds | input | 16 | Data segment register value |
| offset | input | 16 | Offset within the segment |
| pfx_valid | input | 1 | Override prefix consumed this cycle |
| pfx_seg | input | 2 | Segment named by the prefix |
| insn_end | input | 1 | Instruction boundary strobe |
| phys_addr | output | 20 | Physical address |
| seg_used | output | 2 | Segment code that supplied the base |

## Verification
The assertions assume that every input is a known value at each rising edge. They also assume that the strobes are single-cycle decisions sampled only at that edge. The override checks look one cycle back to the strobe values, so they rely on the reference kind in the following cycle being the one the core really issues. The stimulus changes inputs only on falling edges. It draws reference kinds over all eight codes, including the spare ones, and fires prefixes and boundaries at random, sometimes on the same edge. This keeps every input known while covering every legal pairing of strobes.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  ref_kind,
  input  logic [15:0] seg_es,
  input  logic [15:0] seg_cs,
  input  logic [15:0] seg_ss,
  input  logic [15:0] seg_ds,
  input  logic [15:0] offset,
  input  logic        pfx_valid,
  input  logic [1:0]  pfx_seg,
  input  logic        insn_end,
  output logic [19:0] phys_addr,
  output logic [1:0]  seg_used
);
  localparam logic [1:0] SEG_E = 2'b00, SEG_C = 2'b01, SEG_S = 2'b10, SEG_D = 2'b11;

  logic       ovr_on;
  logic [1:0] ovr_seg;
  logic [15:0] base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_on  <= 1'b0;
      ovr_seg <= SEG_D;
    end else if (pfx_valid) begin
      ovr_on  <= 1'b1;
      ovr_seg <= pfx_seg;
    end else if (insn_end) begin
      ovr_on  <= 1'b0;
    end
  end

  always_comb begin
    case (ref_kind)
      3'd0:    seg_used = SEG_C;
      3'd1:    seg_used = SEG_S;
      3'd4:    seg_used = SEG_E;
      3'd5:    seg_used = ovr_on ? ovr_seg : SEG_S;
      default: seg_used = ovr_on ? ovr_seg : SEG_D;
    endcase
  end

  always_comb begin
    case (seg_used)
      SEG_E:   base = seg_es;
      SEG_C:   base = seg_cs;
      SEG_S:   base = seg_ss;
      default: base = seg_ds;
    endcase
  end

  assign phys_addr = {base, 4'b0000} + {4'b0000, offset};

  assert_low_nibble_R1: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[3:0] == offset[3:0]);
  assert_fetch_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_kind == 3'd0 |-> seg_used == 2'b01);
  assert_stack_ss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_kind == 3'd1 |-> seg_used == 2'b10);
  assert_pfx_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_valid |=> (ref_kind != 3'd2 || seg_used == $past(pfx_seg)));
  assert_dst_extra_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_kind == 3'd4 |-> seg_used == 2'b00);
  assert_ovr_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_end && !pfx_valid) |=> (ref_kind != 3'd5 || seg_used == 2'b10));
endmodule

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]  ref_kind = 3'd2;
  logic [15:0] seg_es = 16'h1000, seg_cs = 16'h2000, seg_ss = 16'h3000, seg_ds = 16'h4000;
  logic [15:0] offset = 16'h0000;
  logic        pfx_valid = 1'b0;
  logic [1:0]  pfx_seg = 2'b00;
  logic        insn_end = 1'b0;
  logic [19:0] phys_addr;
  logic [1:0]  seg_used;

  int total = 0, bad = 0;
  bit m_on = 1'b0;
  logic [1:0] m_seg = 2'b11;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  seg_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .ref_kind(ref_kind),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .offset(offset), .pfx_valid(pfx_valid), .pfx_seg(pfx_seg),
    .insn_end(insn_end), .phys_addr(phys_addr), .seg_used(seg_used)
  );

  function automatic logic [1:0] exp_seg(input logic [2:0] k, input bit on, input logic [1:0] s);
    case (k)
      3'd0: return 2'b01;
      3'd1: return 2'b10;
      3'd4: return 2'b00;
      3'd5: return on ? s : 2'b10;
      default: return on ? s : 2'b11;
    endcase
  endfunction

  function automatic logic [19:0] exp_addr(input logic [1:0] s, input logic [15:0] es, cs, ss, ds, off);
    logic [15:0] b;
    case (s)
      2'b00: b = es;
      2'b01: b = cs;
      2'b10: b = ss;
      default: b = ds;
    endcase
    return {b, 4'b0} + {4'b0, off};
  endfunction

  function automatic string tag_of(input logic [2:0] k);
    case (k)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R4";
    endcase
  endfunction

  task automatic check_now(input string tag);
    logic [1:0] es_v;
    logic [19:0] ea;
    es_v = exp_seg(ref_kind, m_on, m_seg);
    ea = exp_addr(es_v, seg_es, seg_cs, seg_ss, seg_ds, offset);
    total++;
    if (seg_used !== es_v) begin
      bad++;
      $display("FAIL %s seg_used actual=%b expected=%b", tag, seg_used, es_v);
    end
    total++;
    if (phys_addr !== ea) begin
      bad++;
      $display("FAIL R1 phys_addr actual=%h expected=%h", phys_addr, ea);
    end
  endtask

  task automatic step(input logic [2:0] k, input logic [15:0] off,
                      input logic pv, input logic [1:0] ps, input logic ie, input string tag);
    @(negedge clk);
    ref_kind = k; offset = off; pfx_valid = pv; pfx_seg = ps; insn_end = ie;
    #1 check_now(tag);
    if (pv) begin m_on = 1'b1; m_seg = ps; end
    else if (ie) m_on = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    #1 check_now("R9");
    @(negedge clk) rst_n = 1'b1;
    #1 check_now("R9");

    // R1 wrap past bit 19
    seg_ds = 16'hFFFF;
    step(3'd2, 16'hFFFF, 1'b0, 2'b00, 1'b0, "R1");
    seg_ds = 16'h4000;
    // R8: prefix then ignored on fetch/stack/dst, honoured on var/src/bp
    step(3'd0, 16'h0010, 1'b1, 2'b00, 1'b0, "R8");
    step(3'd0, 16'h0020, 1'b0, 2'b00, 1'b0, "R2");
    step(3'd1, 16'h0030, 1'b0, 2'b00, 1'b0, "R3");
    step(3'd4, 16'h0040, 1'b0, 2'b01, 1'b0, "R6");
    step(3'd2, 16'h0050, 1'b0, 2'b00, 1'b0, "R4");
    step(3'd3, 16'h0060, 1'b0, 2'b00, 1'b0, "R5");
    step(3'd5, 16'h0070, 1'b0, 2'b00, 1'b1, "R7");
    step(3'd5, 16'h0080, 1'b0, 2'b00, 1'b0, "R8");
    // both strobes on one edge: prefix kept
    step(3'd2, 16'h0090, 1'b1, 2'b01, 1'b1, "R8");
    step(3'd2, 16'h00A0, 1'b0, 2'b00, 1'b0, "R8");
    step(3'd6, 16'h00B0, 1'b0, 2'b00, 1'b1, "R4");
    step(3'd7, 16'h00C0, 1'b0, 2'b00, 1'b0, "R4");

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] k;
      k = 3'($urandom_range(0, 7));
      if (($urandom & 15) == 0) begin
        seg_es = 16'($urandom); seg_cs = 16'($urandom);
        seg_ss = 16'($urandom); seg_ds = 16'($urandom);
      end
      step(k, 16'($urandom), ($urandom_range(0, 5) == 0), 2'($urandom),
           ($urandom_range(0, 3) == 0), tag_of(k));
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule